// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block models a clocked, single-port, common-I/O SRAM with burst addressing. Each word has `LANES` byte lanes of `LANE_W` bits each (four 9-bit lanes by default). Every clock cycle the block looks at three chip enables, two start strobes, an advance input, the write controls, an output-enable and a sleep input. From these it picks one of six operations: deselect, begin burst, continue burst, suspend burst, sleep, or nothing. It writes into an internal array under a byte mask, or returns a registered read word. It also produces the enable for the shared data-bus drivers.

One start strobe belongs to the processor and the other to the cache or memory controller. The processor strobe always starts a read, and it is ignored while the first enable is inactive. The controller strobe can start a read or a write. A burst walks four addresses inside an aligned group of four. By default it uses an XOR (interleaved) order. A parameter selects a wrapping increment (linear) order instead.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A cycle is a deselect when the controller strobe is low while `ce_a_n` is high, or when a start strobe is accepted while `ce_b` is low or `ce_c_n` is high. A deselect reads and writes nothing, so `rvalid` is 0 in the next cycle. It also ends the open burst, so a later advance does not access the array.
- R2: With `ce_a_n` low and `start_cpu_n` low, and the other two enables active, a read burst starts at `addr` even when the write inputs are asserted. While `ce_a_n` is high, `start_cpu_n` is ignored.
- R3: With `start_ctl_n` low, `start_cpu_n` high and all enables active, a burst starts at `addr`. It is a write when a write is requested and a read otherwise. `adv_n` has no effect in that cycle.
- R4: With no start accepted, `start_ctl_n` high and a burst open, the low two address bits change as follows. `adv_n` low moves to the next count; `adv_n` high keeps the current address. The rest of the address stays at the burst base. For count k and starting low bits s, the low bits are s XOR k (default) or (s+k) mod 4 (linear option), so the burst wraps after four.
- R5: `wr_all_n` low writes every lane. With `wr_all_n` high and `wr_byte_n` low, exactly the lanes g with `lane_sel_n[g]` low are written; lane g is `wdata[9g+8:9g]`. With both high, or with no lane selected, the cycle is a read.
- R6: Lanes that are not selected keep their contents. A write takes effect in one clock, so a read in the very next cycle returns the new data.
- R7: `bus_drive` is 0 in any cycle that performs a write, whatever the level of `oe_n`. In a cycle that presents read data, `bus_drive` is high exactly when `oe_n` is low.
- R8: While `sleep` is high, no access takes place, `bus_drive` is 0 and the stored data is kept.
- R9: Accesses stay blocked for two cycles after `sleep` falls. Sleep also ends the open burst.
- R10: Read data and `rvalid`=1 appear in the cycle after the address cycle of a read.
- R11: During and after reset, `rvalid` and `bus_drive` are 0 and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_a_n | input | 1 | First chip enable, active low |
| ce_b | input | 1 | Second chip enable, active high |
| ce_c_n | input | 1 | Third chip enable, active low |
| start_cpu_n | input | 1 | Processor start strobe, active low |
| start_ctl_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_byte_n | input | 1 | Byte-lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Sleep request |
| addr | input | AW | Word address |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rvalid | output | 1 | Read data valid |
| bus_drive | output | 1 | Enable for the shared bus drivers |

## Verification
The hardest collision is a write cycle that arrives while the read word from the previous cycle is still on `rdata`. The bus enable must then drop at once, even though `oe_n` is low. The bench starts a read, then drives a controller write in the following cycle and samples `bus_drive` before the write edge. The expected value is 0, although `rvalid` is 1 at that moment. A second collision is a sleep request in the cycle just after a read. The same early sample must show the drivers off. Later reads of the target address show whether any of the strobes attempted during sleep or during the two recovery cycles wrote to the array.

// File: rtl/burst_sram_pkg.sv
`timescale 1ns/100ps
package burst_sram_pkg;
   typedef enum logic [2:0] {
      OP_IDLE,
      OP_DESEL,
      OP_SLEEP,
      OP_START,
      OP_NEXT,
      OP_HOLD
   } bsr_op_e;
endpackage

// File: rtl/bsr_sleep_gate.sv
`timescale 1ns/100ps
module bsr_sleep_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep,
   output logic gate
);
   logic [1:0] hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= '0;
      else        hold_q <= {hold_q[0], sleep};
   end

   assign gate = sleep | hold_q[0] | hold_q[1];
endmodule

// File: rtl/bsr_decode.sv
`timescale 1ns/100ps
module bsr_decode
   import burst_sram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             ce_a_n,
   input  logic             ce_b,
   input  logic             ce_c_n,
   input  logic             start_cpu_n,
   input  logic             start_ctl_n,
   input  logic             adv_n,
   input  logic             wr_all_n,
   input  logic             wr_byte_n,
   input  logic [LANES-1:0] lane_sel_n,
   input  logic             gate,
   input  logic             live,
   output bsr_op_e          op,
   output logic             is_wr,
   output logic [LANES-1:0] lane_we
);
   logic             wr_req;
   logic             en_ok;
   logic [LANES-1:0] lanes;

   always_comb begin
      wr_req = !wr_all_n || (!wr_byte_n && !(&lane_sel_n));
      lanes  = !wr_all_n ? '1 : (!wr_byte_n ? ~lane_sel_n : '0);
      en_ok  = ce_b && !ce_c_n;
      op     = OP_IDLE;
      is_wr  = 1'b0;
      if (gate) begin
         op = OP_SLEEP;
      end else if (!ce_a_n && !start_cpu_n) begin
         op = en_ok ? OP_START : OP_DESEL;
      end else if (!start_ctl_n) begin
         if (ce_a_n || !en_ok) begin
            op = OP_DESEL;
         end else begin
            op    = OP_START;
            is_wr = wr_req;
         end
      end else if (live) begin
         op    = adv_n ? OP_HOLD : OP_NEXT;
         is_wr = wr_req;
      end
      lane_we = is_wr ? lanes : '0;
   end
endmodule

// File: rtl/bsr_burst_addr.sv
`timescale 1ns/100ps
module bsr_burst_addr
   import burst_sram_pkg::*;
#(
   parameter int AW     = 8,
   parameter bit LINEAR = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  bsr_op_e       op,
   input  logic [AW-1:0] addr,
   output logic [AW-1:0] acc_addr,
   output logic          live
);
   logic [AW-1:0] base_q;
   logic [1:0]    cnt_q;
   logic [1:0]    cnt_use;
   logic [1:0]    low;
   logic          live_q;

   assign cnt_use = (op == OP_NEXT) ? cnt_q + 2'd1 : cnt_q;

   generate
      if (LINEAR) begin : g_linear
         assign low = base_q[1:0] + cnt_use;
      end else begin : g_interleave
         assign low = base_q[1:0] ^ cnt_use;
      end
   endgenerate

   assign acc_addr = (op == OP_START) ? addr : {base_q[AW-1:2], low};
   assign live     = live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         live_q <= 1'b0;
      end else begin
         case (op)
            OP_START: begin
               base_q <= addr;
               cnt_q  <= '0;
               live_q <= 1'b1;
            end
            OP_NEXT:  cnt_q  <= cnt_q + 2'd1;
            OP_DESEL,
            OP_SLEEP: live_q <= 1'b0;
            default:  ;
         endcase
      end
   end

   // R4: a suspend keeps the address of the previous burst cycle
   p_hold_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && op == OP_HOLD &&
       $past(op) inside {OP_START, OP_NEXT, OP_HOLD})
      |-> acc_addr == $past(acc_addr));

   // R4: an advance moves to a different address within the group of four
   p_next_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && op == OP_NEXT &&
       $past(op) inside {OP_START, OP_NEXT, OP_HOLD})
      |-> (acc_addr != $past(acc_addr) &&
           acc_addr[AW-1:2] == $past(acc_addr[AW-1:2])));
endmodule

// File: rtl/bsr_lane_array.sv
`timescale 1ns/100ps
module bsr_lane_array #(
   parameter int DEPTH  = 256,
   parameter int AW     = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   localparam int WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic [LANES-1:0]  lane_we,
   input  logic              rd_en,
   input  logic [AW-1:0]     acc_addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata
);
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic [LANE_W-1:0] rd_q;

      always_ff @(posedge clk) begin
         if (lane_we[g]) mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
         if (rd_en)      rd_q <= mem[acc_addr];
      end

      assign rdata[g*LANE_W +: LANE_W] = rd_q;
   end
endmodule

// File: rtl/burst_sram_ctrl.sv
`timescale 1ns/100ps
module burst_sram_ctrl
   import burst_sram_pkg::*;
#(
   parameter int DEPTH  = 256,
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter bit LINEAR = 1'b0,
   localparam int AW     = $clog2(DEPTH),
   localparam int WORD_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_a_n,
   input  logic              ce_b,
   input  logic              ce_c_n,
   input  logic              start_cpu_n,
   input  logic              start_ctl_n,
   input  logic              adv_n,
   input  logic              wr_all_n,
   input  logic              wr_byte_n,
   input  logic [LANES-1:0]  lane_sel_n,
   input  logic              oe_n,
   input  logic              sleep,
   input  logic [AW-1:0]     addr,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   output logic              rvalid,
   output logic              bus_drive
);
   if (DEPTH < 4 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two and at least 4");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("LANES and LANE_W must be positive");
   end

   bsr_op_e          op;
   logic             is_wr;
   logic [LANES-1:0] lane_we;
   logic             gate;
   logic             live;
   logic [AW-1:0]    acc_addr;
   logic             rd_fire;
   logic             rvalid_q;

   bsr_sleep_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .sleep (sleep),
      .gate  (gate)
   );

   bsr_decode #(.LANES(LANES)) u_dec (
      .ce_a_n      (ce_a_n),
      .ce_b        (ce_b),
      .ce_c_n      (ce_c_n),
      .start_cpu_n (start_cpu_n),
      .start_ctl_n (start_ctl_n),
      .adv_n       (adv_n),
      .wr_all_n    (wr_all_n),
      .wr_byte_n   (wr_byte_n),
      .lane_sel_n  (lane_sel_n),
      .gate        (gate),
      .live        (live),
      .op          (op),
      .is_wr       (is_wr),
      .lane_we     (lane_we)
   );

   bsr_burst_addr #(.AW(AW), .LINEAR(LINEAR)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .addr     (addr),
      .acc_addr (acc_addr),
      .live     (live)
   );

   assign rd_fire = (op inside {OP_START, OP_NEXT, OP_HOLD}) && !is_wr;

   bsr_lane_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
      .clk      (clk),
      .lane_we  (lane_we),
      .rd_en    (rd_fire),
      .acc_addr (acc_addr),
      .wdata    (wdata),
      .rdata    (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid_q <= 1'b0;
      else        rvalid_q <= rd_fire;
   end

   assign rvalid    = rvalid_q;
   assign bus_drive = rvalid_q && !oe_n && !is_wr && !gate;

   // R8: no lane is written while sleep is requested
   p_sleep_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> lane_we == '0);

   // R8: drivers stay off while asleep
   p_sleep_bus_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !bus_drive);

   // R9: the cycle after sleep is still blocked
   p_recover_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sleep)) |-> op == OP_SLEEP);

   // R5: a global write enables every lane
   p_all_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_all_n && lane_we != '0) |-> (&lane_we));

   // R7: drivers are off in any writing cycle
   p_bus_off_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_we != '0) |-> !bus_drive);

   // R10: a processor-started read yields valid data one cycle later
   p_read_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_START && !ce_a_n && !start_cpu_n) |=> rvalid);
endmodule

// File: tb/burst_sram_ctrl_bench.sv
`timescale 1ns/100ps
module burst_sram_ctrl_bench;
   localparam int  DEPTH  = 256;
   localparam int  LANES  = 4;
   localparam int  LANE_W = 9;
   localparam bit  LIN    = 1'b0;
   localparam int  WW     = LANES * LANE_W;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          ce_a_n, ce_b, ce_c_n, start_cpu_n, start_ctl_n, adv_n;
   logic          wr_all_n, wr_byte_n, oe_n, sleep;
   logic [3:0]    lane_sel_n;
   logic [7:0]    addr;
   logic [WW-1:0] wdata;
   logic [WW-1:0] rdata;
   logic          rvalid, bus_drive;

   logic [WW-1:0] ref_mem [DEPTH];
   int n_tests = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   burst_sram_ctrl #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .LINEAR(LIN)) u_burst_sram_ctrl (
      .clk(clk), .rst_n(rst_n), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
      .start_cpu_n(start_cpu_n), .start_ctl_n(start_ctl_n), .adv_n(adv_n),
      .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .lane_sel_n(lane_sel_n),
      .oe_n(oe_n), .sleep(sleep), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rvalid(rvalid), .bus_drive(bus_drive)
   );

   function automatic logic [WW-1:0] pat(int a);
      logic [7:0] b;
      b = a[7:0];
      return {b[3:0] ^ 4'h9, {4{b}} ^ 32'hC35A96E1};
   endfunction

   function automatic int seq(int base, int k);
      logic [1:0] s;
      logic [1:0] kk;
      logic [1:0] lo;
      s  = base[1:0];
      kk = k[1:0];
      lo = LIN ? s + kk : s ^ kk;
      return (base & 'hFC) | int'(lo);
   endfunction

   task automatic report();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   task automatic chk(string req, logic [WW-1:0] act, logic [WW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle_in();
      ce_a_n = 0; ce_b = 1; ce_c_n = 0;
      start_cpu_n = 1; start_ctl_n = 1; adv_n = 1;
      wr_all_n = 1; wr_byte_n = 1; lane_sel_n = '1;
      oe_n = 0; sleep = 0;
   endtask

   task automatic go();
      @(posedge clk); #1;
   endtask

   task automatic expect_rd(string req, int a);
      chk(req, WW'(rvalid), WW'(1));
      chk(req, rdata, ref_mem[a]);
   endtask

   task automatic model_wr(int a, logic [WW-1:0] d, logic gw, logic bwe, logic [3:0] bw);
      for (int l = 0; l < LANES; l++)
         if (!gw || (!bwe && !bw[l])) ref_mem[a][l*LANE_W +: LANE_W] = d[l*LANE_W +: LANE_W];
   endtask

   task automatic ctl_write(int a, logic [WW-1:0] d, logic gw, logic bwe, logic [3:0] bw);
      @(negedge clk); idle_in();
      start_ctl_n = 0; addr = a[7:0]; wdata = d;
      wr_all_n = gw; wr_byte_n = bwe; lane_sel_n = bw;
      model_wr(a, d, gw, bwe, bw);
      go();
   endtask

   task automatic cpu_read(int a, string req);
      @(negedge clk); idle_in();
      start_cpu_n = 0; addr = a[7:0]; wr_all_n = 0; wdata = ~pat(a);
      go();
      expect_rd(req, a);
   endtask

   task automatic ctl_read(int a, string req);
      @(negedge clk); idle_in();
      start_ctl_n = 0; adv_n = 0; addr = a[7:0];
      go();
      expect_rd(req, a);
   endtask

   task automatic step_rd(logic adv, int exp_a, string req);
      @(negedge clk); idle_in();
      adv_n = ~adv;
      go();
      expect_rd(req, exp_a);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      report();
   end

   initial begin
      idle_in(); addr = '0; wdata = '0; rst_n = 0;
      repeat (3) @(posedge clk);
      #1;
      // R11: outputs quiet in reset
      chk("R11", WW'(rvalid), '0);
      chk("R11", WW'(bus_drive), '0);
      @(negedge clk); rst_n = 1;
      go();
      chk("R11", WW'(rvalid), '0);
      // R11: no burst open, so an advance reads nothing
      @(negedge clk); idle_in(); adv_n = 0;
      go();
      chk("R11", WW'(rvalid), '0);

      // R3 R5: fill the whole array with controller global writes
      for (int a = 0; a < DEPTH; a++) ctl_write(a, pat(a), 1'b0, 1'b1, 4'hF);
      // R2: processor strobe reads even with global write asserted
      for (int a = 0; a < DEPTH; a++) cpu_read(a, "R2");
      // R3: controller read start with advance low (ignored)
      for (int a = 0; a < 64; a++) ctl_read(a * 4 + 1, "R3");

      // R5 R6: every lane-strobe code, read back in the next cycle
      for (int c = 0; c < 16; c++) begin
         ctl_write(16 + c, ~pat(16 + c), 1'b1, 1'b0, c[3:0]);
         cpu_read(16 + c, "R6");
      end
      // R5: both write controls high is a read whatever the lane strobes
      ctl_write(40, 36'h0_0000_0000, 1'b1, 1'b1, 4'h0);
      expect_rd("R5", 40);
      cpu_read(40, "R5");

      // R7: a write cycle right after a read turns the drivers off
      cpu_read(5, "R10");
      chk("R7", WW'(bus_drive), WW'(1));
      @(negedge clk); idle_in();
      start_ctl_n = 0; addr = 8'd6; wr_all_n = 0; wdata = 36'hA_5A5A_5A5A;
      #0.5;
      chk("R7", WW'(rvalid), WW'(1));
      chk("R7", WW'(bus_drive), '0);
      model_wr(6, 36'hA_5A5A_5A5A, 1'b0, 1'b1, 4'hF);
      go();
      // R7: read with output enable high, then low
      @(negedge clk); idle_in(); start_cpu_n = 0; addr = 8'd6; oe_n = 1;
      go();
      expect_rd("R7", 6);
      chk("R7", WW'(bus_drive), '0);
      oe_n = 0; #0.5;
      chk("R7", WW'(bus_drive), WW'(1));

      // R4: burst order for every starting offset, with wrap and suspend
      for (int s = 0; s < 4; s++) begin
         ctl_read(64 + s, "R4");
         for (int k = 1; k <= 4; k++) step_rd(1'b1, seq(64 + s, k), "R4");
         step_rd(1'b0, seq(64 + s, 4), "R4");
      end
      // R4 R3: burst write via continue and suspend
      ctl_write(128, 36'h1_1111_1111, 1'b0, 1'b1, 4'hF);
      for (int k = 1; k < 4; k++) begin
         @(negedge clk); idle_in();
         adv_n = 0; wr_all_n = 0; wdata = 36'h2_0000_0000 + 36'(k);
         model_wr(seq(128, k), wdata, 1'b0, 1'b1, 4'hF);
         go();
      end
      @(negedge clk); idle_in();
      wr_byte_n = 0; lane_sel_n = 4'b1110; wdata = 36'h0_0000_01FF;
      model_wr(seq(128, 3), wdata, 1'b1, 1'b0, 4'b1110);
      go();
      for (int k = 0; k < 4; k++) cpu_read(seq(128, k), "R4");

      // R1: deselect via first enable with controller strobe
      ctl_read(200, "R1");
      @(negedge clk); idle_in();
      ce_a_n = 1; start_ctl_n = 0; addr = 8'd201; wr_all_n = 0; wdata = '1;
      go();
      chk("R1", WW'(rvalid), '0);
      @(negedge clk); idle_in(); adv_n = 0;
      go();
      chk("R1", WW'(rvalid), '0);
      cpu_read(201, "R1");
      // R1: second enable low with processor strobe
      @(negedge clk); idle_in(); ce_b = 0; start_cpu_n = 0; addr = 8'd202;
      go();
      chk("R1", WW'(rvalid), '0);
      // R1: third enable high with controller write
      @(negedge clk); idle_in(); ce_c_n = 1; start_ctl_n = 0; addr = 8'd203;
      wr_all_n = 0; wdata = '0;
      go();
      chk("R1", WW'(rvalid), '0);
      cpu_read(203, "R1");
      // R2: processor strobe ignored while first enable is inactive
      ctl_read(204, "R2");
      @(negedge clk); idle_in();
      ce_a_n = 1; start_cpu_n = 0; addr = 8'd10; adv_n = 0;
      go();
      expect_rd("R2", seq(204, 1));

      // R8: sleep right after a read
      ctl_read(220, "R8");
      @(negedge clk); idle_in();
      sleep = 1; start_ctl_n = 0; addr = 8'd220; wr_all_n = 0; wdata = 36'h3_3333_3333;
      #0.5;
      chk("R8", WW'(bus_drive), '0);
      go();
      chk("R8", WW'(rvalid), '0);
      @(negedge clk); start_ctl_n = 1; start_cpu_n = 0;
      go();
      chk("R8", WW'(rvalid), '0);
      // R9: two blocked cycles after release
      for (int i = 0; i < 2; i++) begin
         @(negedge clk); idle_in();
         start_ctl_n = 0; addr = 8'd220; wr_all_n = 0; wdata = 36'h4_4444_4444 + 36'(i);
         go();
         chk("R9", WW'(rvalid), '0);
      end
      // R9: burst was closed by sleep
      @(negedge clk); idle_in(); adv_n = 0;
      go();
      chk("R9", WW'(rvalid), '0);
      cpu_read(220, "R8");

      report();
   end
endmodule